// File: doc/BRIEF.md
# PCI configuration cycle decoder

This block is the front end of a memory-mapped host bridge. A CPU-side register bus presents an access with an offset, a byte count and write data. The two top bits of the offset pick one of three windows. One window holds a 32-bit configuration-address register. One is a configuration-data window that launches a configuration cycle. The remaining offsets pass straight through as I/O requests. An access to the data window decodes the stored address into a cycle type, a bus, device and function number, a dword register index and a byte lane. From these the block drives a one-hot slot select, or else a flag saying that nothing answered.

Type 0 cycles locate their target through a one-hot select field in the upper address bits, checked against a mask of occupied slots. The slot at device 11 is the bridge's own configuration function, and it is always present. Type 1 cycles are decoded and shown on the outputs, but no downstream bus exists behind this bridge, so they never reach a target. Every read gets its answer in the cycle after the request. A target that does not respond reads as all ones. An unclaimed I/O read returns zero.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: Offset bits 23:22 select the window. A value of 2 selects the address register, 3 selects the data window, and 0 or 1 selects I/O. An I/O access raises only `io_req`. A data access raises exactly one of `cfg_req` and `cfg_miss`. An address-window access raises none of the three.
- R2: The address register resets to zero. It takes all 32 bits of `req_wdata` on a write to window 2 and holds its value under every other access. A read of window 2 returns the stored value.
- R3: `cfg_type1` equals bit 0 of the address register. A value of 1 means a type 1 cycle and 0 means type 0.
- R4: For a type 1 cycle, `cfg_bus` is address bits 23:16, `cfg_dev` is bits 15:11 and `cfg_func` is bits 10:8. A type 1 access never asserts `cfg_req` or `cfg_sel`: it raises `cfg_miss`, a read returns 0xFFFFFFFF, and a write is dropped.
- R5: For both cycle types, `cfg_func` is address bits 10:8 and `cfg_reg` is address bits 7:2 (a dword index). `cfg_byte` is `req_offset[1:0]`.
- R6: For a type 0 cycle, address bits 31:11 form the select field. If exactly bit k is set and the slot is present (`slot_present[k-11]`), the block asserts `cfg_req`, sets only bit k-11 of `cfg_sel`, and drives `cfg_dev` = k. A read then returns `cfg_rdata`.
- R7: Select bit 11 (device 11, slot 0) is the bridge itself. It asserts `cfg_self` and is selected whatever the value of `slot_present[0]`.
- R8: A type 0 data access whose select field is zero or has two or more bits set selects nothing and raises `cfg_miss`. It drives `err_idsel` high for exactly the following cycle. A read of this kind returns 0xFFFFFFFF.
- R9: A valid one-hot select whose slot bit in `slot_present` is clear raises `cfg_miss` without `cfg_req` or `err_idsel`. A read of this kind returns 0xFFFFFFFF.
- R10: `rsp_valid` is high in the cycle after each read request and low after writes and idle cycles. `rsp_rdata` carries the value for that read.
- R11: An I/O access drives `io_req` with `io_offset`, `io_size`, `io_wdata` and `io_write` copied from the request. A read returns `io_rdata` when `io_ack` is high in the request cycle, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 24 | Access offset within the bridge region |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| slot_present | input | 21 | Occupied type 0 slots, bit n = device n+11 |
| cfg_req | output | 1 | Configuration cycle to a selected target |
| cfg_write | output | 1 | Direction of the configuration cycle |
| cfg_type1 | output | 1 | Cycle type from the address register |
| cfg_bus | output | 8 | Bus number (type 1) |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_byte | output | 2 | Byte offset within the dword |
| cfg_size | output | 3 | Access size in bytes |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_sel | output | 21 | One-hot target slot select |
| cfg_self | output | 1 | Target is the bridge's own function |
| cfg_miss | output | 1 | Data access that reached no target |
| cfg_rdata | input | 32 | Read data from the selected target |
| io_req | output | 1 | I/O window access |
| io_write | output | 1 | I/O direction |
| io_offset | output | 24 | I/O offset |
| io_size | output | 3 | I/O size in bytes |
| io_wdata | output | 32 | I/O write data |
| io_ack | input | 1 | I/O access claimed |
| io_rdata | input | 32 | I/O read data |
| err_idsel | output | 1 | One-cycle pulse after an invalid select field |

## Verification
The bench walks every one of the 21 select positions under three occupancy masks, including one with the bridge's own bit cleared. A decoder that counted the device number from the wrong base, dropped the self slot or ignored the mask would then select the wrong slot or miss. It feeds zero and two-bit select fields. A check that tested only for a nonzero field would select a target there instead of reporting an error and returning all ones. Type 1 addresses with several bus, device and function patterns expose a field taken from the wrong bits, or a type 1 cycle leaking through to a type 0 slot. Claimed and unclaimed I/O reads separate a zero return from an all-ones return. Writes to the data window check that they leave the address register unchanged.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  typedef enum logic [1:0] {
    WIN_IO_LO = 2'd0,
    WIN_IO_HI = 2'd1,
    WIN_ADDR  = 2'd2,
    WIN_DATA  = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    SRC_ADDR = 3'd0,
    SRC_CFG  = 3'd1,
    SRC_ONES = 3'd2,
    SRC_IO   = 3'd3,
    SRC_ZERO = 3'd4
  } rd_src_e;

  typedef struct packed {
    logic       type1;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regno;
  } cfg_fields_t;

endpackage

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (we_i) q_nxt = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end

endmodule

// File: rtl/cfgdec_idsel.sv
module cfgdec_idsel #(
  parameter int SLOTS = 21,
  parameter int DEV_W = 5,
  parameter int BASE  = 11
) (
  input  logic [SLOTS-1:0] idsel_i,
  output logic             valid_o,
  output logic [DEV_W-1:0] dev_o
);

  logic             any_set;
  logic             multi_set;
  logic [DEV_W-1:0] idx;

  // With a single set bit, the OR of the indices of the set bits is that bit's index.
  always_comb begin
    any_set   = 1'b0;
    multi_set = 1'b0;
    idx       = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (idsel_i[i]) begin
        multi_set = multi_set | any_set;
        any_set   = 1'b1;
        idx       = idx | DEV_W'(i);
      end
    end
  end

  assign valid_o = any_set & ~multi_set;
  assign dev_o   = valid_o ? (idx + DEV_W'(BASE)) : '0;

endmodule

// File: rtl/cfgdec_route.sv
module cfgdec_route
  import cfgdec_pkg::*;
#(
  parameter int SLOTS = 21,
  parameter int DEV_W = 5
) (
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [1:0]          win_i,
  input  cfg_fields_t         fld_i,
  input  logic [SLOTS-1:0]    idsel_i,
  input  logic                idsel_valid_i,
  input  logic [DEV_W-1:0]    idsel_dev_i,
  input  logic [SLOTS-1:0]    slot_present_i,
  input  logic                io_ack_i,
  output logic                cfg_req_o,
  output logic                cfg_miss_o,
  output logic                cfg_self_o,
  output logic [SLOTS-1:0]    cfg_sel_o,
  output logic [DEV_W-1:0]    cfg_dev_o,
  output logic                err_now_o,
  output logic                io_req_o,
  output logic                addr_we_o,
  output logic                rd_fire_o,
  output rd_src_e             rd_src_o
);

  win_e             win;
  logic             is_data;
  logic             is_addr;
  logic             is_io;
  logic [SLOTS-1:0] present_eff;
  logic [SLOTS-1:0] hit_vec;
  logic             t0_hit;

  assign win = win_e'(win_i);

  // Slot 0 is the bridge's own function and is always present.
  genvar gk;
  generate
    for (gk = 0; gk < SLOTS; gk++) begin : g_slot
      if (gk == 0) begin : g_self
        assign present_eff[gk] = 1'b1 | slot_present_i[gk];
      end else begin : g_ext
        assign present_eff[gk] = slot_present_i[gk];
      end
      assign hit_vec[gk] = idsel_i[gk] & present_eff[gk];
    end
  endgenerate

  always_comb begin
    is_data = req_valid_i && (win == WIN_DATA);
    is_addr = req_valid_i && (win == WIN_ADDR);
    is_io   = req_valid_i && ((win == WIN_IO_LO) || (win == WIN_IO_HI));
    t0_hit  = is_data && !fld_i.type1 && idsel_valid_i && (|hit_vec);
  end

  always_comb begin
    cfg_req_o  = t0_hit;
    cfg_miss_o = is_data && !t0_hit;
    cfg_sel_o  = t0_hit ? hit_vec : '0;
    cfg_self_o = t0_hit && hit_vec[0];
    cfg_dev_o  = fld_i.type1 ? fld_i.dev : idsel_dev_i;
    err_now_o  = is_data && !fld_i.type1 && !idsel_valid_i;
    io_req_o   = is_io;
    addr_we_o  = is_addr && req_write_i;
    rd_fire_o  = req_valid_i && !req_write_i;
  end

  always_comb begin
    rd_src_o = SRC_ZERO;
    unique case (win)
      WIN_ADDR:  rd_src_o = SRC_ADDR;
      WIN_DATA:  rd_src_o = t0_hit ? SRC_CFG : SRC_ONES;
      default:   rd_src_o = io_ack_i ? SRC_IO : SRC_ZERO;
    endcase
  end

endmodule

// File: rtl/cfgdec_rsp.sv
module cfgdec_rsp
  import cfgdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire_i,
  input  rd_src_e           rd_src_i,
  input  logic              err_now_i,
  input  logic [DATA_W-1:0] addr_q_i,
  input  logic [DATA_W-1:0] cfg_rdata_i,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o
);

  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    unique case (rd_src_i)
      SRC_ADDR: sel_data = addr_q_i;
      SRC_CFG:  sel_data = cfg_rdata_i;
      SRC_ONES: sel_data = '1;
      SRC_IO:   sel_data = io_rdata_i;
      default:  sel_data = '0;
    endcase
    data_nxt = rsp_rdata_o;
    if (rd_fire_i) data_nxt = sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= rd_fire_i;
      rsp_rdata_o <= data_nxt;
      err_o       <= err_now_i;
    end
  end

endmodule

// File: rtl/cfg_cycle_decoder.sv
module cfg_cycle_decoder
  import cfgdec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFFS_W    = 24,
  parameter int SIZE_W    = 3,
  parameter int IDSEL_LSB = 11,
  parameter int DEV_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [OFFS_W-1:0]             req_offset,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic [DATA_W-IDSEL_LSB-1:0]   slot_present,
  output logic                          cfg_req,
  output logic                          cfg_write,
  output logic                          cfg_type1,
  output logic [7:0]                    cfg_bus,
  output logic [DEV_W-1:0]              cfg_dev,
  output logic [2:0]                    cfg_func,
  output logic [5:0]                    cfg_reg,
  output logic [1:0]                    cfg_byte,
  output logic [SIZE_W-1:0]             cfg_size,
  output logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-IDSEL_LSB-1:0]   cfg_sel,
  output logic                          cfg_self,
  output logic                          cfg_miss,
  input  logic [DATA_W-1:0]             cfg_rdata,
  output logic                          io_req,
  output logic                          io_write,
  output logic [OFFS_W-1:0]             io_offset,
  output logic [SIZE_W-1:0]             io_size,
  output logic [DATA_W-1:0]             io_wdata,
  input  logic                          io_ack,
  input  logic [DATA_W-1:0]             io_rdata,
  output logic                          err_idsel
);

  localparam int SLOTS = DATA_W - IDSEL_LSB;

  logic [DATA_W-1:0] addr_q;
  cfg_fields_t       fld;
  logic              idsel_valid;
  logic [DEV_W-1:0]  idsel_dev;
  logic              err_now;
  logic              addr_we;
  logic              rd_fire;
  rd_src_e           rd_src;

  assign fld = '{type1: addr_q[0],
                 bus:   addr_q[23:16],
                 dev:   addr_q[15:11],
                 func:  addr_q[10:8],
                 regno: addr_q[7:2]};

  cfgdec_addr_reg #(.DATA_W(DATA_W)) i_addr_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (addr_we),
    .wdata_i (req_wdata),
    .q_o     (addr_q)
  );

  cfgdec_idsel #(.SLOTS(SLOTS), .DEV_W(DEV_W), .BASE(IDSEL_LSB)) i_idsel (
    .idsel_i (addr_q[DATA_W-1:IDSEL_LSB]),
    .valid_o (idsel_valid),
    .dev_o   (idsel_dev)
  );

  cfgdec_route #(.SLOTS(SLOTS), .DEV_W(DEV_W)) i_route (
    .req_valid_i    (req_valid),
    .req_write_i    (req_write),
    .win_i          (req_offset[OFFS_W-1 -: 2]),
    .fld_i          (fld),
    .idsel_i        (addr_q[DATA_W-1:IDSEL_LSB]),
    .idsel_valid_i  (idsel_valid),
    .idsel_dev_i    (idsel_dev),
    .slot_present_i (slot_present),
    .io_ack_i       (io_ack),
    .cfg_req_o      (cfg_req),
    .cfg_miss_o     (cfg_miss),
    .cfg_self_o     (cfg_self),
    .cfg_sel_o      (cfg_sel),
    .cfg_dev_o      (cfg_dev),
    .err_now_o      (err_now),
    .io_req_o       (io_req),
    .addr_we_o      (addr_we),
    .rd_fire_o      (rd_fire),
    .rd_src_o       (rd_src)
  );

  cfgdec_rsp #(.DATA_W(DATA_W)) i_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire_i   (rd_fire),
    .rd_src_i    (rd_src),
    .err_now_i   (err_now),
    .addr_q_i    (addr_q),
    .cfg_rdata_i (cfg_rdata),
    .io_rdata_i  (io_rdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .err_o       (err_idsel)
  );

  assign cfg_write = req_write;
  assign cfg_type1 = fld.type1;
  assign cfg_bus   = fld.bus;
  assign cfg_func  = fld.func;
  assign cfg_reg   = fld.regno;
  assign cfg_byte  = req_offset[1:0];
  assign cfg_size  = req_size;
  assign cfg_wdata = req_wdata;
  assign io_write  = req_write;
  assign io_offset = req_offset;
  assign io_size   = req_size;
  assign io_wdata  = req_wdata;

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker #(
  parameter int DATA_W    = 32,
  parameter int OFFS_W    = 24,
  parameter int IDSEL_LSB = 11,
  parameter int DEV_W     = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [OFFS_W-1:0]           req_offset,
  input logic [DATA_W-1:0]           addr_q,
  input logic                        cfg_req,
  input logic                        cfg_miss,
  input logic                        cfg_self,
  input logic [DEV_W-1:0]            cfg_dev,
  input logic [DATA_W-IDSEL_LSB-1:0] cfg_sel,
  input logic                        io_req,
  input logic                        rsp_valid,
  input logic [DATA_W-1:0]           rsp_rdata,
  input logic                        err_idsel
);

  localparam int SLOTS = DATA_W - IDSEL_LSB;

  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (!cfg_req && !cfg_miss)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && (req_offset[OFFS_W-1 -: 2] == 2'b10)) |=> $stable(addr_q)); // R2

  AST_TYPE1_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_offset[OFFS_W-1 -: 2] == 2'b11) && addr_q[0]) |-> (!cfg_req && cfg_miss)); // R4

  AST_SEL_MATCHES_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_sel == (SLOTS'(1) << (cfg_dev - DEV_W'(IDSEL_LSB))))); // R6

  AST_SELF_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_self |-> (cfg_dev == DEV_W'(IDSEL_LSB))); // R7

  AST_ERR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (err_idsel && rsp_valid) |-> (rsp_rdata == '1)); // R8

  AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_miss |-> ((cfg_sel == '0) && !cfg_req)); // R9

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10

  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R10

endmodule

bind cfg_cycle_decoder cfgdec_checker #(
  .DATA_W(DATA_W), .OFFS_W(OFFS_W), .IDSEL_LSB(IDSEL_LSB), .DEV_W(DEV_W)
) i_cfgdec_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_offset (req_offset),
  .addr_q     (addr_q),
  .cfg_req    (cfg_req),
  .cfg_miss   (cfg_miss),
  .cfg_self   (cfg_self),
  .cfg_dev    (cfg_dev),
  .cfg_sel    (cfg_sel),
  .io_req     (io_req),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .err_idsel  (err_idsel)
);

// File: tb/test_cfg_cycle_decoder.sv
`timescale 1ns/1ps
module test_cfg_cycle_decoder;

  localparam real CLK_P = 4.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [23:0] req_offset;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [20:0] slot_present;
  logic        cfg_req, cfg_write, cfg_type1;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [1:0]  cfg_byte;
  logic [2:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic [20:0] cfg_sel;
  logic        cfg_self, cfg_miss;
  logic [31:0] cfg_rdata;
  logic        io_req, io_write;
  logic [23:0] io_offset;
  logic [2:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        err_idsel;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Captured outputs: c_* in the request cycle, r_* one cycle later.
  logic        c_req, c_miss, c_self, c_type1, c_io;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_reg;
  logic [1:0]  c_byte;
  logic [20:0] c_sel;
  logic [23:0] c_iooff;
  logic [2:0]  c_iosz;
  logic        r_valid, r_err;
  logic [31:0] r_data;

  always #(CLK_P/2) clk = ~clk;

  // Target model: returns a word built from the decoded device and register.
  assign cfg_rdata = {16'hC0DE, 3'b000, cfg_dev, 2'b00, cfg_reg};

  cfg_cycle_decoder i_cfg_cycle_decoder (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [23:0] off, input logic [31:0] wd, input logic [2:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off; req_wdata = wd; req_size = sz;
    #1;
    c_req = cfg_req; c_miss = cfg_miss; c_self = cfg_self; c_type1 = cfg_type1;
    c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func; c_reg = cfg_reg; c_byte = cfg_byte;
    c_sel = cfg_sel; c_io = io_req; c_iooff = io_offset; c_iosz = io_size;
    @(posedge clk); #1;
    r_valid = rsp_valid; r_err = err_idsel; r_data = rsp_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(posedge clk); #1;
    r_valid = rsp_valid; r_err = err_idsel; r_data = rsp_rdata;
  endtask

  function automatic logic [23:0] woff(input logic [1:0] w, input logic [1:0] b);
    return {w, 20'h0, b};
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [31:0] masks [3];
    masks[0] = 32'h001F_FFFF; masks[1] = 32'h000A_AAAA; masks[2] = 32'h0;
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_offset = '0; req_size = 3'd4;
    req_wdata = '0; slot_present = '1; io_ack = 0; io_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(err_idsel == 1'b0, "R8 reset err_idsel", {31'b0, err_idsel}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 reset value and read-back
    access(0, woff(2'd2, 2'd0), '0, 3'd4);
    chk(r_valid && r_data == 32'h0, "R2 reset addr", r_data, 32'h0);
    access(1, woff(2'd2, 2'd0), 32'h1234_5678, 3'd4);
    chk(r_valid == 1'b0, "R10 no rsp after write", {31'b0, r_valid}, 32'h0);
    chk(!c_req && !c_miss && !c_io, "R1 addr window quiet", {29'b0, c_req, c_miss, c_io}, 32'h0);
    access(0, woff(2'd2, 2'd0), '0, 3'd4);
    chk(r_data == 32'h1234_5678, "R2 addr readback", r_data, 32'h1234_5678);
    idle();
    chk(r_valid == 1'b0, "R10 no rsp after idle", {31'b0, r_valid}, 32'h0);

    // R3/R4/R5 type 1 decode
    for (int t = 0; t < 6; t++) begin
      logic [7:0] bus; logic [4:0] dv; logic [2:0] fn; logic [5:0] rg; logic [1:0] by;
      bus = 8'(t * 37 + 1); dv = 5'(t * 7 + 3); fn = 3'(t + 2); rg = 6'(t * 11 + 5); by = 2'(t);
      a = {8'h00, bus, dv, fn, rg, 2'b01};
      access(1, woff(2'd2, 2'd0), a, 3'd4);
      access(0, woff(2'd3, by), '0, 3'd1);
      chk(c_type1 == 1'b1, "R3 type1 bit", {31'b0, c_type1}, 32'h1);
      chk(c_bus == bus && c_dev == dv, "R4 bus/dev", {19'b0, c_bus, c_dev}, {19'b0, bus, dv});
      chk(c_func == fn && c_reg == rg && c_byte == by, "R5 func/reg/byte",
          {21'b0, c_func, c_reg, c_byte}, {21'b0, fn, rg, by});
      chk(c_miss && !c_req && c_sel == '0, "R4 type1 no target", {30'b0, c_miss, c_req}, 32'h2);
      chk(r_valid && r_data == 32'hFFFF_FFFF, "R4 type1 read ones", r_data, 32'hFFFF_FFFF);
      access(1, woff(2'd3, 2'd0), 32'hDEAD_BEEF, 3'd4);
      chk(!c_req, "R4 type1 write dropped", {31'b0, c_req}, 32'h0);
      access(0, woff(2'd2, 2'd0), '0, 3'd4);
      chk(r_data == a, "R2 addr kept after data write", r_data, a);
    end

    // R6/R7/R9 type 0 sweep over every select position and three masks
    for (int m = 0; m < 3; m++) begin
      slot_present = masks[m][20:0];
      for (int k = 0; k < 21; k++) begin
        logic pres; logic [2:0] fn; logic [5:0] rg; logic [31:0] exp_rd;
        fn = 3'(k % 8); rg = 6'(k * 3 + m);
        pres = (k == 0) || masks[m][k];
        a = (32'h1 << (k + 11)) | {21'b0, fn, rg, 2'b00};
        access(1, woff(2'd2, 2'd0), a, 3'd4);
        access(0, woff(2'd3, 2'(k)), '0, 3'd2);
        chk(c_type1 == 1'b0, "R3 type0 bit", {31'b0, c_type1}, 32'h0);
        chk(c_func == fn && c_reg == rg, "R5 type0 func/reg", {23'b0, c_func, c_reg}, {23'b0, fn, rg});
        chk(r_err == 1'b0, "R9 no error on valid select", {31'b0, r_err}, 32'h0);
        if (pres) begin
          exp_rd = {16'hC0DE, 3'b000, 5'(k + 11), 2'b00, rg};
          chk(c_req && !c_miss, "R6 selected", {30'b0, c_req, c_miss}, 32'h2);
          chk(c_sel == (21'h1 << k), "R6 cfg_sel", {11'b0, c_sel}, {11'b0, 21'h1 << k});
          chk(c_dev == 5'(k + 11), "R6 cfg_dev", {27'b0, c_dev}, 32'(k + 11));
          chk(c_self == (k == 0), "R7 cfg_self", {31'b0, c_self}, {31'b0, (k == 0)});
          chk(r_data == exp_rd, "R6 read data", r_data, exp_rd);
        end else begin
          chk(c_miss && !c_req && c_sel == '0, "R9 absent miss", {30'b0, c_miss, c_req}, 32'h2);
          chk(r_data == 32'hFFFF_FFFF, "R9 absent read ones", r_data, 32'hFFFF_FFFF);
        end
      end
    end
    slot_present = '1;

    // R8 invalid select fields: zero and two-bit patterns
    for (int p = 0; p < 8; p++) begin
      logic [20:0] sel;
      sel = (p == 0) ? 21'h0 : ((21'h1 << (p - 1)) | (21'h1 << (p * 2 + 3)));
      a = {sel, 3'd1, 6'd9, 2'b00};
      access(1, woff(2'd2, 2'd0), a, 3'd4);
      access(0, woff(2'd3, 2'd0), '0, 3'd4);
      chk(c_miss && !c_req && c_sel == '0, "R8 invalid no target", {30'b0, c_miss, c_req}, 32'h2);
      chk(r_err == 1'b1, "R8 err pulse", {31'b0, r_err}, 32'h1);
      chk(r_data == 32'hFFFF_FFFF, "R8 read ones", r_data, 32'hFFFF_FFFF);
      idle();
      chk(r_err == 1'b0, "R8 err one cycle", {31'b0, r_err}, 32'h0);
      access(1, woff(2'd3, 2'd0), 32'h5555_AAAA, 3'd4);
      chk(!c_req && r_err, "R8 write dropped with err", {30'b0, c_req, r_err}, 32'h1);
    end

    // R1/R11 I/O window
    for (int q = 0; q < 4; q++) begin
      logic [23:0] off; logic [31:0] d;
      off = {1'b0, 1'(q), 22'(q * 24'h01_2345 + 3)};
      d = 32'hA000_0000 + 32'(q);
      io_rdata = d; io_ack = q[0];
      access(0, off, '0, 3'(q + 1));
      chk(c_io && !c_req && !c_miss, "R1 io window", {29'b0, c_io, c_req, c_miss}, 32'h4);
      chk(c_iooff == off && c_iosz == 3'(q + 1), "R11 io fields", {5'b0, c_iosz, c_iooff}, {5'b0, 3'(q + 1), off});
      chk(r_data == (q[0] ? d : 32'h0), "R11 io read", r_data, q[0] ? d : 32'h0);
    end
    io_ack = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule